// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

This block takes eight interrupt request lines from peripherals and presents one interrupt request to a processor that has a single request/acknowledge pair. When the processor acknowledges, the controller picks the highest-priority eligible line. One cycle later it returns an 8-bit vector for that line, made of a programmable 5-bit base in the upper bits and the 3-bit line number in the lower bits. The chosen line then enters the in-service set and stays there until software writes an end-of-interrupt command.

Software sets the controller through a small register write port. It can choose a fixed-order mode or a rotating mode, mask any line, and set the vector base. A line's request is caught in a request latch and waits there while the line is masked or blocked. A line that is in service blocks lines of equal or lower priority. A line of higher priority can still preempt it. In rotating mode, the line cleared by end-of-interrupt becomes the lowest priority, so lines that share a level take fair turns.

A control state machine with three states sequences the processor handshake:
- **IDLE**: no request is presented. It moves to RAISE when an eligible request exists (transition *arm*).
- **RAISE**: the interrupt output is high. It moves to DELIVER on acknowledge while a request is still eligible (transition *take*). It falls back to IDLE if the request stops being eligible, for example when the line is masked (transition *withdraw*).
- **DELIVER**: the vector is valid for exactly one cycle. It then returns to IDLE (transition *finish*).

Top module: `pic8_ctrl`

## Requirements
- R1: After reset, `int_req` and `vec_valid` are low. All lines are unmasked, the mode is fixed order, the vector base is 0 and the rotation pointer marks line 7 as lowest.
- R2: A high level on `irq_lines[i]` is caught in a request latch at the next clock edge. The latched bit stays set after the line falls, and is cleared only when line i is acknowledged.
- R3: A line whose mask bit is 1 never raises `int_req` and is never selected. Its latched request survives the mask and is served after the line is unmasked. Masked lines do not block other lines.
- R4: In fixed-order mode, the lowest-numbered eligible line wins: line 0 is highest and line 7 is lowest.
- R5: A line in service blocks every pending line of equal or lower priority from raising `int_req`. A strictly higher-priority line is still served and nests on top of it.
- R6: From a request line going high, `int_req` rises on the second clock edge if the line is eligible. After an acknowledge sampled in RAISE, `vec_valid` is high for exactly one cycle and `vec_out` = {base[4:0], line[2:0]}.
- R7: An end-of-interrupt command clears only the highest-priority in-service bit. With nothing in service, it changes no state, including the rotation pointer.
- R8: In rotating mode, the line after the pointer (pointer+1 mod 8) has the highest priority. End-of-interrupt sets the pointer to the line it cleared. In fixed-order mode the pointer is ignored.
- R9: A write with `cfg_we`=1 uses `cfg_sel` as follows:
  - 0 selects the mode, where bit 0 = 1 means rotating.
  - 1 selects the mask, where bit i masks line i.
  - 2 selects the vector base, taken from bits 4:0.
  - 3 is end-of-interrupt, and its data is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 8 | Level-sensitive request lines, one per peripheral |
| int_req | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Interrupt acknowledge from the processor |
| vec_out | output | 8 | Vector {base, line number} |
| vec_valid | output | 1 | Vector valid, one cycle |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 mask, 2 base, 3 end-of-interrupt |
| cfg_wdata | input | 8 | Register write data |

## Verification
The assertions check on every cycle that:
- an acknowledged line is never masked and always outranks the in-service set;
- the vector pulse lasts one cycle and carries the line that was taken;
- an acknowledge clears the latched request;
- each acknowledge adds exactly one in-service bit, and each end-of-interrupt removes exactly one;
- an end-of-interrupt with nothing in service leaves the rotation pointer unchanged.

Only the bench scenarios can show the ordering results:
- which line wins for every pair of lines in fixed-order mode;
- the exact rotation order over repeated turns;
- preemption and release across a nested service;
- requests that are held while masked and served once the mask is removed.

// File: rtl/pic8_pkg.sv
package pic8_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RAISE   = 2'd1,
        ST_DELIVER = 2'd2
    } pic_state_t;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_BASE = 2'd2,
        SEL_EOI  = 2'd3
    } cfg_sel_t;

endpackage

// File: rtl/pic8_pick.sv
// Rotating priority picker: the bit right after low_ptr is highest priority.
module pic8_pick #(
    parameter  int IDX_W = 3,
    localparam int N     = 1 << IDX_W
) (
    input  logic [N-1:0]     bits,
    input  logic [IDX_W-1:0] low_ptr,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] rank
);

    logic [N-1:0] rot;

    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_rot
            logic [IDX_W-1:0] pos;
            assign pos    = low_ptr + IDX_W'(k + 1);
            assign rot[k] = bits[pos];
        end
    endgenerate

    always_comb begin
        found = 1'b0;
        rank  = '0;
        for (int j = N - 1; j >= 0; j--) begin
            if (rot[j]) begin
                found = 1'b1;
                rank  = IDX_W'(j);
            end
        end
    end

    assign idx = low_ptr + rank + 1'b1;

endmodule

// File: rtl/pic8_latch.sv
// Request latch: level inputs set bits, acknowledge clears the chosen bit.
module pic8_latch #(
    parameter  int IDX_W = 3,
    localparam int N     = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     lines,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [N-1:0]     irr
);

    logic [N-1:0] clr_vec;

    always_comb begin
        clr_vec = '0;
        if (clr_en) clr_vec[clr_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irr <= '0;
        else        irr <= (irr | lines) & ~clr_vec;
    end

    // R2: an acknowledged request is gone right after the acknowledge edge
    p_ack_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !irr[$past(clr_idx)]);

endmodule

// File: rtl/pic8_svc.sv
// In-service set and rotation pointer; end-of-interrupt handling.
module pic8_svc #(
    parameter  int IDX_W = 3,
    localparam int N     = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             eoi,
    input  logic             rotate,
    output logic [N-1:0]     isr,
    output logic [IDX_W-1:0] eff_ptr,
    output logic             isr_any,
    output logic [IDX_W-1:0] isr_rank
);

    logic [IDX_W-1:0] rot_ptr;
    logic [IDX_W-1:0] top_idx;
    logic [N-1:0]     set_vec;
    logic [N-1:0]     eoi_vec;

    assign eff_ptr = rotate ? rot_ptr : {IDX_W{1'b1}};

    pic8_pick #(.IDX_W(IDX_W)) u_top (
        .bits    (isr),
        .low_ptr (eff_ptr),
        .found   (isr_any),
        .idx     (top_idx),
        .rank    (isr_rank)
    );

    always_comb begin
        set_vec = '0;
        eoi_vec = '0;
        if (set_en)            set_vec[set_idx] = 1'b1;
        if (eoi && isr_any)    eoi_vec[top_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr     <= '0;
            rot_ptr <= {IDX_W{1'b1}};
        end else begin
            isr <= (isr & ~eoi_vec) | set_vec;
            if (eoi && isr_any && rotate) rot_ptr <= top_idx;
        end
    end

    // R5: each acknowledge adds exactly one in-service bit
    p_set_adds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !eoi && !isr[set_idx]) |=>
            ($countones(isr) == $past($countones(isr)) + 1));

    // R7: end-of-interrupt removes exactly one bit
    p_eoi_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && isr_any && !set_en) |=>
            ($countones(isr) == $past($countones(isr)) - 1));

    // R7: end-of-interrupt with nothing in service leaves the pointer alone
    p_eoi_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !isr_any) |=> $stable(rot_ptr));

endmodule

// File: rtl/pic8_ctrl.sv
// Top: configuration registers, eligibility and processor handshake FSM.
module pic8_ctrl
    import pic8_pkg::*;
#(
    parameter  int IDX_W  = 3,
    parameter  int VEC_W  = 8,
    localparam int N      = 1 << IDX_W,
    localparam int BASE_W = VEC_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     irq_lines,
    output logic             int_req,
    input  logic             int_ack,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [N-1:0]     cfg_wdata
);

    pic_state_t        state_q, state_d;
    logic              rot_mode;
    logic [N-1:0]      mask_q;
    logic [BASE_W-1:0] base_q;
    logic [VEC_W-1:0]  vec_q;

    logic [N-1:0]      irr;
    logic [N-1:0]      pending;
    logic [N-1:0]      isr;
    logic              cand_found;
    logic [IDX_W-1:0]  cand_idx;
    logic [IDX_W-1:0]  cand_rank;
    logic [IDX_W-1:0]  eff_ptr;
    logic              isr_any;
    logic [IDX_W-1:0]  isr_rank;
    logic              eligible;
    logic              take;
    logic              eoi_pulse;

    // configuration write port (R9)
    assign eoi_pulse = cfg_we && (cfg_sel == SEL_EOI);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rot_mode <= 1'b0;
            mask_q   <= '0;
            base_q   <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel_t'(cfg_sel))
                SEL_MODE: rot_mode <= cfg_wdata[0];
                SEL_MASK: mask_q   <= cfg_wdata;
                SEL_BASE: base_q   <= cfg_wdata[BASE_W-1:0];
                SEL_EOI:  ;
            endcase
        end
    end

    pic8_latch #(.IDX_W(IDX_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines   (irq_lines),
        .clr_en  (take),
        .clr_idx (cand_idx),
        .irr     (irr)
    );

    assign pending = irr & ~mask_q;

    pic8_pick #(.IDX_W(IDX_W)) u_cand (
        .bits    (pending),
        .low_ptr (eff_ptr),
        .found   (cand_found),
        .idx     (cand_idx),
        .rank    (cand_rank)
    );

    pic8_svc #(.IDX_W(IDX_W)) u_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (take),
        .set_idx  (cand_idx),
        .eoi      (eoi_pulse),
        .rotate   (rot_mode),
        .isr      (isr),
        .eff_ptr  (eff_ptr),
        .isr_any  (isr_any),
        .isr_rank (isr_rank)
    );

    assign eligible = cand_found && (!isr_any || (cand_rank < isr_rank));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: arm, take, withdraw, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (eligible) state_d = ST_RAISE;
            ST_RAISE: begin
                if (!eligible)    state_d = ST_IDLE;
                else if (int_ack) state_d = ST_DELIVER;
            end
            ST_DELIVER: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        int_req   = 1'b0;
        vec_valid = 1'b0;
        take      = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_RAISE: begin
                int_req = 1'b1;
                take    = int_ack && eligible;
            end
            ST_DELIVER: vec_valid = 1'b1;
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    vec_q <= '0;
        else if (take) vec_q <= {base_q, cand_idx};
    end

    assign vec_out = vec_q;

    // R6: the vector pulse lasts one cycle
    p_vec_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R6: the cycle after a take carries that line's vector
    p_vec_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (vec_valid && (vec_out[IDX_W-1:0] == $past(cand_idx))));

    // R3: a masked line is never taken
    p_take_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !mask_q[cand_idx]);

    // R5: a taken line outranks everything already in service
    p_take_outranks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (!isr_any || (cand_rank < isr_rank)));

endmodule

// File: tb/pic8_ctrl_tb_top.sv
`timescale 1ns/1ps
module pic8_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] irq_lines;
    logic       int_req;
    logic       int_ack;
    logic [7:0] vec_out;
    logic       vec_valid;
    logic       cfg_we;
    logic [1:0] cfg_sel;
    logic [7:0] cfg_wdata;

    int         checks = 0;
    int         fails  = 0;
    logic [4:0] base_m = 5'd0;
    int         ptr_m  = 7;

    always #2.5 clk = ~clk;

    pic8_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .int_req   (int_req),
        .int_ack   (int_ack),
        .vec_out   (vec_out),
        .vec_valid (vec_valid),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic eoi();
        cfg(2'd3, 8'hA5);
    endtask

    // wait for int_req, acknowledge, drop the served line, check the vector
    task automatic serve(input int idx, input string tag);
        int n;
        logic [7:0] exp_v;
        n = 0;
        exp_v = {base_m, 3'(idx)};
        while (!int_req && n < 20) begin
            @(negedge clk);
            n++;
        end
        if (!int_req) begin
            chk(1'b0, {tag, " int_req"}, 0, 1);
        end else begin
            int_ack = 1'b1;
            irq_lines[idx] = 1'b0;
            @(negedge clk);
            int_ack = 1'b0;
            chk(vec_valid && (vec_out == exp_v), tag, int'(vec_out), int'(exp_v));
        end
    endtask

    task automatic quiet(input int n, input string tag);
        bit seen;
        seen = 1'b0;
        repeat (n) begin
            @(negedge clk);
            if (int_req) seen = 1'b1;
        end
        chk(!seen, tag, int'(seen), 0);
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_lines = '0; int_ack = 1'b0;
        cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!int_req, "R1 int_req low", int'(int_req), 0);
        chk(!vec_valid, "R1 vec_valid low", int'(vec_valid), 0);
        irq_lines[4] = 1'b1;
        serve(4, "R1 base zero after reset");
        eoi();

        // R6 timing: raised on the second edge, vector pulse one cycle
        irq_lines[2] = 1'b1;
        @(negedge clk);
        chk(!int_req, "R6 not raised after one edge", int'(int_req), 0);
        @(negedge clk);
        chk(int_req, "R6 raised after two edges", int'(int_req), 1);
        serve(2, "R6 vector");
        @(negedge clk);
        chk(!vec_valid, "R6 vec_valid one cycle", int'(vec_valid), 0);
        eoi();

        // R9 base register
        cfg(2'd2, 8'hF3);
        base_m = 5'h13;

        // R4 each line alone
        for (int i = 0; i < 8; i++) begin
            irq_lines[i] = 1'b1;
            serve(i, "R4 single line");
            eoi();
        end

        // R4 every pair: lower number first
        for (int a = 0; a < 8; a++) begin
            for (int b = a + 1; b < 8; b++) begin
                irq_lines[a] = 1'b1;
                irq_lines[b] = 1'b1;
                serve(a, "R4 pair winner");
                eoi();
                serve(b, "R4 pair loser");
                eoi();
            end
        end

        // R5 nesting
        irq_lines[5] = 1'b1;
        serve(5, "R5 first service");
        irq_lines[6] = 1'b1;
        irq_lines[5] = 1'b1;
        quiet(10, "R5 equal and lower blocked");
        irq_lines[2] = 1'b1;
        serve(2, "R5 higher preempts");
        eoi();
        quiet(8, "R7 eoi cleared only top, 5 still blocks");
        eoi();
        serve(5, "R5 released after eoi");
        eoi();
        serve(6, "R5 lowest last");
        eoi();

        // R3 masking
        cfg(2'd1, 8'h08);
        irq_lines[3] = 1'b1;
        quiet(10, "R3 masked line silent");
        irq_lines[5] = 1'b1;
        serve(5, "R3 masked line does not block");
        eoi();
        quiet(6, "R3 still masked");
        cfg(2'd1, 8'h00);
        serve(3, "R3 latched request served after unmask");
        eoi();

        // R2 a one-cycle pulse is held in the latch
        @(negedge clk);
        irq_lines[1] = 1'b1;
        @(negedge clk);
        irq_lines[1] = 1'b0;
        serve(1, "R2 pulse latched");
        eoi();
        quiet(8, "R2 latch cleared by acknowledge");

        // R7 / R8 rotating mode, empty eoi first
        cfg(2'd0, 8'h01);
        eoi();
        irq_lines[0] = 1'b1;
        irq_lines[7] = 1'b1;
        serve(0, "R7 empty eoi keeps pointer");
        eoi();
        ptr_m = 0;
        serve(7, "R8 pointer moved to served line");
        eoi();
        ptr_m = 7;

        // R8 fair turns with all lines requesting
        irq_lines = 8'hFF;
        for (int it = 0; it < 15; it++) begin
            int exp_i;
            exp_i = (ptr_m + 1) % 8;
            serve(exp_i, "R8 rotation order");
            if (it < 7) irq_lines[exp_i] = 1'b1;
            eoi();
            ptr_m = exp_i;
        end
        quiet(10, "R8 all turns drained");

        // R9 back to fixed order: pointer ignored
        cfg(2'd0, 8'h00);
        irq_lines[6] = 1'b1;
        irq_lines[1] = 1'b1;
        serve(1, "R9 fixed order restored");
        eoi();
        serve(6, "R9 fixed order second");
        eoi();

        summary();
        $finish;
    end

endmodule